// File: doc/BRIEF.md
# LPC I/O Host Engine

This block lets a processor that has no native I/O address space reach byte-wide I/O ports on a Low Pin Count bus. Software sets up a small register file through a simple word-wide register port: how many byte cycles to run, a command word holding the direction and the address mode, and a 16-bit port address. For writes it also pushes the outgoing bytes into a four-entry transmit queue. A write of 1 to bit 0 of the launch register then starts a burst of one to four LPC I/O cycles.

The engine drives the four-bit multiplexed LAD bus and the active-low frame strobe for each byte. It honours the peripheral's SYNC handshake, which may hold the cycle with wait codes, end it with an error code, or stall it past the allowed window. Read bytes land in a four-entry receive queue that software drains through a pop register. Completion is shown by two separate status bits. Idle with finished set means success. Idle with finished clear means the burst failed or has not been run.

The LAD pins are split into an output, an output enable and an input, so that the pad tri-state sits outside the block.

Top module: `lpc_io_host`

## Requirements
- R1: The register offsets are launch 0x00, status 0x04, burst length 0x10, command 0x14, port address 0x20, transmit queue push 0x24 and receive queue pop 0x28. The length, command bits [3:0] and 16-bit port address read back at their own offsets. Status bit 0 is idle and status bit 1 is finished.
- R2: After a synchronous active-low reset, status reads idle=1 and finished=0, the frame strobe is high and the LAD output enable is low.
- R3: Writing 1 to bit 0 of offset 0x00 while idle, with a legal length, makes the engine busy and clears finished. A fault-free burst of N bytes returns to idle with finished=1 exactly 13*N clocks after the launch edge, plus the wait clocks.
- R4: Each byte cycle has the following shape. START nibble 0000 is sent for one clock with the frame strobe low. A cycle-type nibble follows: 0000 for read, 0010 for write. Then come four port-address nibbles, most significant first. A write adds two data nibbles, low nibble first. Then come two turnaround clocks, with 1111 driven on the first and the bus released on the second, then SYNC. A read adds two data nibbles after SYNC. Every cycle ends with two released turnaround clocks.
- R5: Command bit 0 selects the direction: 0 for read, 1 for write. Write bytes are sent in push order. Read bytes are popped from offset 0x28 in cycle order, and a pop of an empty queue returns 0.
- R6: Command bit 3 set keeps every cycle of the burst on the programmed port. Clear, byte k of the burst goes to port+k, modulo 2^16.
- R7: During SYNC, 0101 and 0110 are wait codes. Up to 256 wait clocks per cycle are accepted. The 257th wait clock aborts the burst, leaving idle=1 and finished=0.
- R8: A SYNC code that is neither ready (0000) nor a wait code, such as error 1010, aborts the burst at once. The remaining cycles are not run, and the engine is left with idle=1 and finished=0.
- R9: While busy, writes to the length, command, port address, transmit queue and launch registers have no effect.
- R10: A launch with a length of 0 or more than 4 runs no cycle and leaves the status unchanged.
- R11: The transmit queue holds 4 bytes, and a fifth push is dropped. Unsent transmit bytes are discarded when a burst ends. The receive queue is emptied at each accepted launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the LPC bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x28) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lad_i | input | 4 | LAD bus value from the pads |
| lad_o | output | 4 | LAD bus value to drive |
| lad_oe | output | 1 | LAD output enable |
| lframe_n | output | 1 | Active-low frame strobe |

## Verification
The burst engine is exercised with both directions, lengths of one, three and four bytes, incrementing and fixed port modes, and a port address at 0xFFFE that wraps. Each pattern separates a different fault: a wrong address step, reversed nibble or byte order, or a wrong cycle-type code. Wait runs of zero, a few, exactly 256 and 257 clocks tell an off-by-one in the stall window apart from correct timing, and the exact clock counts expose any extra or missing framing clock. An error code in the middle of a burst, launches while busy and out-of-range lengths show whether the abort and ignore paths leave the right status, queue contents and register values.

// File: rtl/lpcio_pkg.sv
package lpcio_pkg;

  localparam int PORT_AW   = 16;
  localparam int PORT_NIBS = PORT_AW / 4;
  localparam int REG_AW    = 8;
  localparam int REG_DW    = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTYPE, ST_ADDR, ST_WDATA,
    ST_TAR_H, ST_SYNC, ST_RDATA, ST_TAR_P
  } seq_st_e;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_CT_RD  = 4'h0;
  localparam logic [3:0] NIB_CT_WR  = 4'h2;
  localparam logic [3:0] NIB_TAR    = 4'hF;
  localparam logic [3:0] SYNC_RDY   = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_LONG  = 4'h6;

  localparam logic [REG_AW-1:0] OFS_GO   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STAT = 8'h04;
  localparam logic [REG_AW-1:0] OFS_LEN  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CMD  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_PORT = 8'h20;
  localparam logic [REG_AW-1:0] OFS_TXQ  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_RXQ  = 8'h28;

  localparam int CMD_WR_BIT  = 0;
  localparam int CMD_FIX_BIT = 3;

  // Port targeted by byte idx of a burst.
  function automatic logic [PORT_AW-1:0] cyc_port(input logic [PORT_AW-1:0] base,
                                                  input int unsigned idx,
                                                  input logic fixed);
    return fixed ? base : base + PORT_AW'(idx);
  endfunction

  // Address nibble k of a port, most significant first.
  function automatic logic [3:0] port_nib(input logic [PORT_AW-1:0] a,
                                          input int unsigned k);
    return a[PORT_AW-1-4*k -: 4];
  endfunction

  function automatic logic len_ok(input int unsigned len, input int unsigned maxlen);
    return (len >= 1) && (len <= maxlen);
  endfunction

  function automatic logic is_wait(input logic [3:0] n);
    return (n == SYNC_SHORT) || (n == SYNC_LONG);
  endfunction

endpackage

// File: rtl/lpcio_fifo.sv
module lpcio_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          push,
  input  logic [W-1:0]                  din,
  input  logic                          pop,
  output logic [W-1:0]                  dout,
  output logic [$clog2(DEPTH+1)-1:0]    level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rp, wp;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt != CNT_W'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && rst_n && !clr) mem[wp] <= din;
  end

  assign dout  = (cnt == '0) ? '0 : mem[rp];
  assign level = cnt;
endmodule

// File: rtl/lpcio_seq.sv
module lpcio_seq
  import lpcio_pkg::*;
#(
  parameter int MAX_LEN  = 4,
  parameter int MAX_WAIT = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         is_wr,
  input  logic                         fixed,
  input  logic [PORT_AW-1:0]           base,
  input  logic [$clog2(MAX_LEN+1)-1:0] len,
  input  logic [7:0]                   tx_byte,
  output logic                         tx_pop,
  output logic                         rx_push,
  output logic [7:0]                   rx_byte,
  input  logic [3:0]                   lad_i,
  output logic [3:0]                   lad_o,
  output logic                         lad_oe,
  output logic                         lframe_n,
  output logic                         idle,
  output logic                         done_ok,
  output logic                         abort,
  output logic                         sync_err,
  output logic                         wait_over
);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int WCNT_W = $clog2(MAX_WAIT + 1);

  seq_st_e             st;
  logic [1:0]          sub;
  logic [LEN_W-1:0]    idx;
  logic [WCNT_W-1:0]   wcnt;
  logic [3:0]          rx_lo;
  logic [PORT_AW-1:0]  cur_port;
  logic                last_byte, in_sync, sync_ready, sync_wait;

  assign cur_port   = cyc_port(base, 32'(idx), fixed);
  assign last_byte  = (idx == len - LEN_W'(1));
  assign in_sync    = (st == ST_SYNC);
  assign sync_ready = in_sync && (lad_i == SYNC_RDY);
  assign sync_wait  = in_sync && is_wait(lad_i);
  assign wait_over  = sync_wait && (wcnt == WCNT_W'(MAX_WAIT));
  assign sync_err   = in_sync && !sync_ready && !sync_wait;
  assign abort      = sync_err || wait_over;
  assign done_ok    = (st == ST_TAR_P) && (sub == 2'd1) && last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      sub   <= '0;
      idx   <= '0;
      wcnt  <= '0;
      rx_lo <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_START;
          idx <= '0;
          sub <= '0;
        end
        ST_START: st <= ST_CTYPE;
        ST_CTYPE: begin
          st  <= ST_ADDR;
          sub <= '0;
        end
        ST_ADDR: if (sub == 2'(PORT_NIBS - 1)) begin
          sub <= '0;
          st  <= is_wr ? ST_WDATA : ST_TAR_H;
        end else sub <= sub + 1'b1;
        ST_WDATA: if (sub == 2'd1) begin
          sub <= '0;
          st  <= ST_TAR_H;
        end else sub <= sub + 1'b1;
        ST_TAR_H: if (sub == 2'd1) begin
          sub  <= '0;
          wcnt <= '0;
          st   <= ST_SYNC;
        end else sub <= sub + 1'b1;
        ST_SYNC: if (abort) begin
          st <= ST_IDLE;
        end else if (sync_ready) begin
          sub <= '0;
          st  <= is_wr ? ST_TAR_P : ST_RDATA;
        end else wcnt <= wcnt + 1'b1;
        ST_RDATA: if (sub == 2'd0) begin
          rx_lo <= lad_i;
          sub   <= 2'd1;
        end else begin
          sub <= '0;
          st  <= ST_TAR_P;
        end
        ST_TAR_P: if (sub == 2'd1) begin
          sub <= '0;
          if (last_byte) st <= ST_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_START;
          end
        end else sub <= sub + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_START: lad_o = NIB_START;
      ST_CTYPE: lad_o = is_wr ? NIB_CT_WR : NIB_CT_RD;
      ST_ADDR:  lad_o = port_nib(cur_port, 32'(sub));
      ST_WDATA: lad_o = sub[0] ? tx_byte[7:4] : tx_byte[3:0];
      ST_TAR_H: lad_o = NIB_TAR;
      default:  lad_o = 4'h0;
    endcase
  end

  assign idle     = (st == ST_IDLE);
  assign lframe_n = (st != ST_START);
  assign lad_oe   = (st == ST_START) || (st == ST_CTYPE) || (st == ST_ADDR) ||
                    (st == ST_WDATA) || ((st == ST_TAR_H) && (sub == 2'd0));
  assign tx_pop   = (st == ST_WDATA) && (sub == 2'd1);
  assign rx_push  = (st == ST_RDATA) && (sub == 2'd1);
  assign rx_byte  = {lad_i, rx_lo};
endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpcio_pkg::*;
#(
  parameter int MAX_LEN  = 4,
  parameter int MAX_WAIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe,
  output logic              lframe_n
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0]   len_q;
  logic [3:0]         cmd_q;
  logic [PORT_AW-1:0] port_q;
  logic               fin_q;

  logic               eng_idle, done_ok, abort, sync_err, wait_over;
  logic               start_go, seq_end;
  logic               tx_pop, rx_push, tx_push, rx_pop;
  logic [7:0]         tx_head, rx_head, rx_byte;
  logic [CNT_W-1:0]   tx_level, rx_level;
  logic               unused_wd;

  function automatic logic hit(input logic [REG_AW-1:0] ofs);
    return reg_wr && (reg_addr == ofs);
  endfunction

  assign start_go  = hit(OFS_GO) && reg_wdata[0] && eng_idle &&
                     len_ok(32'(len_q), MAX_LEN);
  assign seq_end   = done_ok || abort;
  assign tx_push   = hit(OFS_TXQ) && eng_idle;
  assign rx_pop    = reg_rd && (reg_addr == OFS_RXQ);
  assign unused_wd = ^reg_wdata[REG_DW-1:PORT_AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      cmd_q  <= '0;
      port_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      if (eng_idle) begin
        if (hit(OFS_LEN))  len_q  <= reg_wdata[LEN_W-1:0];
        if (hit(OFS_CMD))  cmd_q  <= reg_wdata[3:0];
        if (hit(OFS_PORT)) port_q <= reg_wdata[PORT_AW-1:0];
      end
      if (start_go)     fin_q <= 1'b0;
      else if (done_ok) fin_q <= 1'b1;
    end
  end

  lpcio_fifo #(.DEPTH(MAX_LEN), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(seq_end), .push(tx_push),
    .din(reg_wdata[7:0]), .pop(tx_pop), .dout(tx_head), .level(tx_level)
  );

  lpcio_fifo #(.DEPTH(MAX_LEN), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .push(rx_push),
    .din(rx_byte), .pop(rx_pop), .dout(rx_head), .level(rx_level)
  );

  lpcio_seq #(.MAX_LEN(MAX_LEN), .MAX_WAIT(MAX_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_go),
    .is_wr(cmd_q[CMD_WR_BIT]), .fixed(cmd_q[CMD_FIX_BIT]),
    .base(port_q), .len(len_q), .tx_byte(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .lad_i(lad_i), .lad_o(lad_o),
    .lad_oe(lad_oe), .lframe_n(lframe_n), .idle(eng_idle),
    .done_ok(done_ok), .abort(abort), .sync_err(sync_err),
    .wait_over(wait_over)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STAT: reg_rdata = {30'b0, fin_q, eng_idle};
      OFS_LEN:  reg_rdata = REG_DW'(len_q);
      OFS_CMD:  reg_rdata = REG_DW'(cmd_q);
      OFS_PORT: reg_rdata = REG_DW'(port_q);
      OFS_RXQ:  reg_rdata = REG_DW'(rx_head);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpcio_chk.sv
module lpcio_chk
  import lpcio_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lframe_n,
  input logic               lad_oe,
  input logic               eng_idle,
  input logic               fin_q,
  input logic               done_ok,
  input logic               abort,
  input logic               sync_err,
  input logic               wait_over,
  input logic               start_go,
  input logic               reg_wr,
  input logic [7:0]         reg_addr,
  input logic [3:0]         cmd_q,
  input logic [PORT_AW-1:0] port_q,
  input logic [CNT_W-1:0]   tx_level,
  input logic [CNT_W-1:0]   rx_level
);
  a_r4_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> (lframe_n && !lad_oe));

  a_r3_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (eng_idle && fin_q));

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (!eng_idle && !fin_q));

  a_r8_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> (eng_idle && !fin_q));

  a_r7_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
    wait_over |=> (eng_idle && !fin_q));

  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_idle && reg_wr && reg_addr == OFS_CMD) |=> $stable(cmd_q));

  a_r9_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_idle && reg_wr && reg_addr == OFS_PORT) |=> $stable(port_q));

  a_r11_tx_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || abort) |=> (tx_level == '0));

  a_r11_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (rx_level == '0));
endmodule

bind lpc_io_host lpcio_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_oe(lad_oe),
  .eng_idle(eng_idle), .fin_q(fin_q), .done_ok(done_ok), .abort(abort),
  .sync_err(sync_err), .wait_over(wait_over), .start_go(start_go),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .cmd_q(cmd_q), .port_q(port_q),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/tb_lpc_io_host.sv
module tb_lpc_io_host;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  // {dir, fixed, len[2:0], port[15:0], waits[7:0], data[31:0]}
  localparam logic [60:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd1, 16'h0080, 8'd0, 32'h000000C3},
    {1'b1, 1'b0, 3'd4, 16'h03F8, 8'd0, 32'h44332211},
    {1'b1, 1'b1, 3'd3, 16'h00E4, 8'd3, 32'h00A0B1C2},
    {1'b0, 1'b0, 3'd2, 16'h0060, 8'd0, 32'h0},
    {1'b0, 1'b1, 3'd4, 16'h02F8, 8'd5, 32'h0},
    {1'b0, 1'b0, 3'd4, 16'hFFFE, 8'd0, 32'h0},
    {1'b1, 1'b0, 3'd2, 16'h1234, 8'd1, 32'h00005A96}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  lad_o;
  logic        lad_oe, lframe_n;

  int nchk = 0, nfail = 0;

  // peripheral model state
  int         pos = 1000, cyc = 0, ncyc = 0, sp = 0, txn_base = 0, frame_bad = 0;
  int         cfg_nwait = 0;
  logic [3:0] cfg_code = 4'h0;
  logic [3:0] ctype [64];
  logic [15:0] laddr [64];
  logic [7:0] lwd [64];
  logic [3:0] wlo;
  logic [7:0] rb;

  lpc_io_host dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lad_i(lad_i), .lad_o(lad_o), .lad_oe(lad_oe), .lframe_n(lframe_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Peripheral: observes the bus at falling edges, answers for the next rising edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      pos   = 1000;
      lad_i = 4'hF;
    end else begin
      if (!lframe_n) begin
        pos = 0;
        cyc = ncyc % 64;
        ncyc = ncyc + 1;
        if (lad_o != 4'h0 || !lad_oe) frame_bad = frame_bad + 1;
      end else if (pos < 1000) pos = pos + 1;
      if (pos == 1) ctype[cyc] = lad_o;
      if (pos >= 2 && pos <= 5) laddr[cyc] = {laddr[cyc][11:0], lad_o};
      if (pos == 6) wlo = lad_o;
      if (pos == 7 && ctype[cyc] == 4'h2) lwd[cyc] = {lad_o, wlo};
      sp = (ctype[cyc] == 4'h2) ? 10 : 8;
      if (pos == sp && lad_oe) frame_bad = frame_bad + 1;
      rb = laddr[cyc][7:0] ^ 8'h3C ^ 8'((cyc - txn_base) * 17);
      lad_i = 4'hF;
      if (pos >= sp && pos < sp + cfg_nwait) lad_i = ((pos - sp) % 2 == 1) ? 4'h6 : 4'h5;
      else if (pos == sp + cfg_nwait) lad_i = cfg_code;
      else if (ctype[cyc] == 4'h0 && pos == sp + cfg_nwait + 1) lad_i = rb[3:0];
      else if (ctype[cyc] == 4'h0 && pos == sp + cfg_nwait + 2) lad_i = rb[7:4];
    end
  end

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(output int clks);
    reg_addr = 8'h04;
    #1;
    clks = 0;
    while (reg_rdata[0] == 1'b0 && clks < 3000) begin
      @(negedge clk);
      #1;
      clks++;
    end
  endtask

  task automatic launch(input bit dir, input bit fix, input logic [2:0] len,
                        input logic [15:0] port, input int nw, input logic [3:0] code,
                        input logic [39:0] data, input int npush);
    cfg_nwait = nw; cfg_code = code; txn_base = ncyc;
    reg_write(8'h10, 32'(len));
    reg_write(8'h14, {28'b0, fix, 2'b00, dir});
    reg_write(8'h20, 32'(port));
    for (int i = 0; i < npush; i++) reg_write(8'h24, 32'(data[8*i +: 8]));
    reg_write(8'h00, 32'h1);
  endtask

  initial begin
    logic [31:0] v;
    int clks, base;
    logic [15:0] ea;
    logic [7:0] eb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_addr = 8'h04;
    #1;
    // R2 reset state
    chk_eq("R2", "status after reset", reg_rdata, 32'h1);
    chk_eq("R2", "frame strobe after reset", lframe_n, 1);
    chk_eq("R2", "lad enable after reset", lad_oe, 0);

    // Table-driven main function: R3 R4 R5 R6
    for (int n = 0; n < NV; n++) begin
      bit dv, fv; logic [2:0] lv; logic [15:0] pv; int wv; logic [31:0] dd;
      dv = VEC[n][60]; fv = VEC[n][59]; lv = VEC[n][58:56];
      pv = VEC[n][55:40]; wv = int'(VEC[n][39:32]); dd = VEC[n][31:0];
      base = ncyc;
      launch(dv, fv, lv, pv, wv, 4'h0, {8'h0, dd}, dv ? int'(lv) : 0);
      wait_idle(clks);
      chk_eq("R3", $sformatf("vec%0d status", n), reg_rdata, 32'h3);
      chk_eq("R3", $sformatf("vec%0d clocks", n), clks, int'(lv) * (13 + wv));
      chk_eq("R3", $sformatf("vec%0d cycle count", n), ncyc - base, int'(lv));
      for (int j = 0; j < int'(lv); j++) begin
        ea = fv ? pv : pv + 16'(j);
        chk_eq("R6", $sformatf("vec%0d byte%0d port", n, j), laddr[(base + j) % 64], ea);
        chk_eq("R4", $sformatf("vec%0d byte%0d cycle type", n, j), ctype[(base + j) % 64],
               dv ? 4'h2 : 4'h0);
        if (dv) chk_eq("R5", $sformatf("vec%0d byte%0d write data", n, j),
                       lwd[(base + j) % 64], dd[8*j +: 8]);
      end
      if (!dv) begin
        for (int j = 0; j < int'(lv); j++) begin
          ea = fv ? pv : pv + 16'(j);
          eb = ea[7:0] ^ 8'h3C ^ 8'(j * 17);
          reg_read(8'h28, v);
          chk_eq("R5", $sformatf("vec%0d read byte%0d", n, j), v, 32'(eb));
        end
        reg_read(8'h28, v);
        chk_eq("R5", $sformatf("vec%0d empty pop", n), v, 0);
      end
    end

    // R1 register read-back
    reg_write(8'h10, 32'h3); reg_write(8'h14, 32'h9); reg_write(8'h20, 32'hA5C3);
    reg_read(8'h10, v); chk_eq("R1", "length readback", v, 3);
    reg_read(8'h14, v); chk_eq("R1", "command readback", v, 9);
    reg_read(8'h20, v); chk_eq("R1", "port readback", v, 32'hA5C3);

    // R10 illegal lengths
    base = ncyc;
    reg_write(8'h10, 32'h0); reg_write(8'h00, 32'h1);
    reg_read(8'h04, v); chk_eq("R10", "status after length 0 launch", v, 32'h3);
    reg_write(8'h10, 32'h5); reg_write(8'h00, 32'h1);
    repeat (20) @(negedge clk);
    reg_read(8'h04, v); chk_eq("R10", "status after length 5 launch", v, 32'h3);
    chk_eq("R10", "no cycles for illegal length", ncyc - base, 0);

    // R8 error SYNC mid burst
    base = ncyc;
    launch(1'b0, 1'b0, 3'd3, 16'h0200, 2, 4'hA, 40'h0, 0);
    wait_idle(clks);
    chk_eq("R8", "status after error sync", reg_rdata, 32'h1);
    chk_eq("R8", "clocks to abort", clks, 11);
    chk_eq("R8", "cycles run before abort", ncyc - base, 1);

    // R7 wait window boundary
    launch(1'b0, 1'b0, 3'd1, 16'h0300, 256, 4'h0, 40'h0, 0);
    wait_idle(clks);
    chk_eq("R7", "256 waits status", reg_rdata, 32'h3);
    chk_eq("R7", "256 waits clocks", clks, 13 + 256);
    launch(1'b0, 1'b0, 3'd1, 16'h0300, 257, 4'h0, 40'h0, 0);
    wait_idle(clks);
    chk_eq("R7", "257 waits status", reg_rdata, 32'h1);
    chk_eq("R7", "257 waits clocks", clks, 8 + 257);

    // R9 writes while busy
    base = ncyc;
    launch(1'b0, 1'b0, 3'd2, 16'h0100, 10, 4'h0, 40'h0, 0);
    reg_write(8'h14, 32'h9);
    reg_write(8'h20, 32'hBEEF);
    reg_write(8'h10, 32'h1);
    reg_write(8'h24, 32'h77);
    reg_write(8'h00, 32'h1);
    wait_idle(clks);
    chk_eq("R9", "status after busy writes", reg_rdata, 32'h3);
    chk_eq("R9", "cycles after busy launch", ncyc - base, 2);
    reg_read(8'h10, v); chk_eq("R9", "length kept", v, 2);
    reg_read(8'h14, v); chk_eq("R9", "command kept", v, 0);
    reg_read(8'h20, v); chk_eq("R9", "port kept", v, 32'h0100);

    // R11 receive queue cleared at launch: pop one of two, then new burst
    reg_read(8'h28, v);
    chk_eq("R5", "first read byte", v, 32'(8'h00 ^ 8'h3C));
    launch(1'b0, 1'b0, 3'd1, 16'h0140, 0, 4'h0, 40'h0, 0);
    wait_idle(clks);
    reg_read(8'h28, v);
    chk_eq("R11", "fresh byte after relaunch", v, 32'(8'h40 ^ 8'h3C));
    reg_read(8'h28, v);
    chk_eq("R11", "stale byte dropped", v, 0);

    // R11 transmit queue overflow and leftover discard
    base = ncyc;
    launch(1'b1, 1'b0, 3'd4, 16'h0400, 0, 4'h0, 40'h5544332211, 5);
    wait_idle(clks);
    for (int j = 0; j < 4; j++)
      chk_eq("R11", $sformatf("overflow byte%0d", j), lwd[(base + j) % 64], 8'(8'h11 * (j + 1)));
    base = ncyc;
    launch(1'b1, 1'b0, 3'd1, 16'h0410, 0, 4'h0, 40'h7766, 2);
    wait_idle(clks);
    chk_eq("R11", "first of two pushed", lwd[base % 64], 8'h66);
    base = ncyc;
    launch(1'b1, 1'b0, 3'd1, 16'h0420, 0, 4'h0, 40'h88, 1);
    wait_idle(clks);
    chk_eq("R11", "leftover discarded", lwd[base % 64], 8'h88);

    chk_eq("R4", "start nibble and released sync", frame_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R3 watchdog: actual cycles %0d expected below %0d", 150000, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule